// File: doc/BRIEF.md
# Audio Serial Port Clock Master

This block produces the two timing clocks of an audio serial port that drives its own clocks: a bit clock and a frame clock. The bit clock is made by dividing the system clock by a programmable amount. The frame clock is made by counting bit clocks. The two divisor inputs each hold the wanted divisor minus one. Software picks the bit-clock divisor as the system clock frequency divided by the product of the sample rate and the number of bit clocks per frame.

In the normal stereo formats (I2S or left-justified), the frame holds word width times channel count bit clocks, for example 64 for two 32-bit words. The frame clock is then a square wave, high for the first half of the frame. In the time-division multiplexed format, the frame length is fixed at 256 bit clocks whatever the frame register holds. The frame clock is then a pulse one bit clock wide. Three single-cycle strobes, in the system clock domain, mark the bit-clock rising and falling edges and the start of each frame, so that neighbouring logic can shift data without sampling the generated clocks.

When the enable is low, the port is a timing slave. The dividers then stay cleared and both generated clocks stay low.

Top module: `audio_clk_master`

## Requirements
- R1: With bit register N ≥ 1 and an even divisor D = N+1, the bit clock has period D system clocks and is high for the first D/2 of them.
- R2: With an odd divisor D ≥ 3, the bit clock is high for (D−1)/2 system clocks and low for (D+1)/2.
- R3: With bit register 0, the bit clock follows the system clock level while enabled, and the rise strobe is high every cycle.
- R4: With the format select low, a frame lasts F+1 bit clocks, where F is the frame register value. The frame clock is high during bit clocks 0 to ⌊(F+1)/2⌋−1 of the frame and rises only at a frame start.
- R5: With an odd frame length, the extra bit clock falls in the low part of the frame clock.
- R6: With the format select high, the frame register is ignored, the frame lasts 256 bit clocks, and the frame clock is high only during bit clock 0 of the frame.
- R7: The rise strobe is high in the system cycle where the bit clock goes high. The fall strobe is high in the cycle where it goes low, which is system-clock index ⌊D/2⌋ of the bit period.
- R8: The frame-start strobe is high exactly in the rise-strobe cycle of bit clock 0 of each frame.
- R9: While reset is asserted, or from the first edge after enable is seen low, all outputs are low and both counters return to zero.
- R10: The first system cycle after enable is first seen high begins a frame: the frame-start strobe, the rise strobe and the bit clock are high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable: high drives the clocks (master), low holds them idle |
| bdiv_i | input | BDIV_W | Bit-clock divisor minus one |
| fdiv_i | input | FDIV_W | Bit clocks per frame minus one (ignored when tdm_i is high) |
| tdm_i | input | 1 | 1: 256-bit frame with a one-bit frame pulse; 0: square-wave frame clock |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| bclk_rise_o | output | 1 | Strobe: bit clock rises in this cycle |
| bclk_fall_o | output | 1 | Strobe: bit clock falls in this cycle |
| frame_start_o | output | 1 | Strobe: first cycle of a frame |

## Verification
The properties assume that the divisor and format inputs hold steady while enable is high. A change in the middle of a frame could shorten the half-frame limit and move a frame-clock edge away from a frame start. The property on the edge strobes also assumes a bit divisor of at least two, because in pass-through mode the bit clock level depends on the clock phase. The bench follows these assumptions: it drops enable, waits a few cycles, loads the new divisors and mode, and only then raises enable again. Reset is pulsed once in the middle of a run.

// File: rtl/audio_clk_master.sv
module audio_clk_master #(
  parameter int BDIV_W = 8,
  parameter int FDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BDIV_W-1:0] bdiv_i,
  input  logic [FDIV_W-1:0] fdiv_i,
  input  logic              tdm_i,
  output logic              bclk_o,
  output logic              fclk_o,
  output logic              bclk_rise_o,
  output logic              bclk_fall_o,
  output logic              frame_start_o
);
  localparam int FCNT_W = (FDIV_W > 8) ? FDIV_W : 8;

  logic              run_q;
  logic [BDIV_W-1:0] bcnt;
  logic [FCNT_W-1:0] fcnt;

  wire [FCNT_W-1:0] flast   = tdm_i ? FCNT_W'(255) : FCNT_W'(fdiv_i);
  wire [BDIV_W:0]   bdivsr  = {1'b0, bdiv_i} + 1'b1;
  wire [BDIV_W-1:0] bhalf   = bdivsr[BDIV_W:1];
  wire [FCNT_W:0]   flen    = {1'b0, flast} + 1'b1;
  wire [FCNT_W-1:0] fhalf   = flen[FCNT_W:1];
  wire              bwrap   = bcnt >= bdiv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      bcnt  <= '0;
      fcnt  <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      bcnt  <= '0;
      fcnt  <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (bwrap) begin
          bcnt <= '0;
          fcnt <= (fcnt >= flast) ? '0 : fcnt + 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  assign bclk_o        = run_q & ((bdiv_i == '0) ? clk : (bcnt < bhalf));
  assign fclk_o        = run_q & (tdm_i ? (fcnt == '0) : (fcnt < fhalf));
  assign bclk_rise_o   = run_q & (bcnt == '0);
  assign bclk_fall_o   = run_q & (bcnt == bhalf);
  assign frame_start_o = run_q & (bcnt == '0) & (fcnt == '0);
endmodule

// File: rtl/audio_clk_master_chk.sv
module audio_clk_master_chk #(
  parameter int BDIV_W = 8,
  parameter int FDIV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [BDIV_W-1:0] bdiv_i,
  input logic [FDIV_W-1:0] fdiv_i,
  input logic              tdm_i,
  input logic              bclk_o,
  input logic              fclk_o,
  input logic              bclk_rise_o,
  input logic              bclk_fall_o,
  input logic              frame_start_o
);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk_o && !fclk_o && !bclk_rise_o && !frame_start_o));

  p_first_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (frame_start_o || !en));

  p_rise_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_rise_o && bdiv_i != '0) |-> bclk_o);

  p_fall_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall_o && bdiv_i != '0) |-> !bclk_o);

  p_start_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> bclk_rise_o);

  p_start_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_o && (tdm_i || fdiv_i != '0)) |-> fclk_o);

  p_fclk_rise_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $rose(fclk_o)) |-> frame_start_o);
endmodule

bind audio_clk_master audio_clk_master_chk #(.BDIV_W(BDIV_W), .FDIV_W(FDIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bdiv_i(bdiv_i), .fdiv_i(fdiv_i), .tdm_i(tdm_i),
  .bclk_o(bclk_o), .fclk_o(fclk_o), .bclk_rise_o(bclk_rise_o),
  .bclk_fall_o(bclk_fall_o), .frame_start_o(frame_start_o)
);

// File: tb/test_audio_clk_master.sv
`timescale 1ns/1ps
module test_audio_clk_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] bdiv = 8'd3;
  logic [7:0] fdiv = 8'd63;
  logic       tdm = 1'b0;
  logic bclk, fclk, rise, fall, fstart;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  bit run = 0;
  bit first = 0;
  int sc = 0;
  int bi = 0;

  always #4 clk = ~clk;

  audio_clk_master #(.BDIV_W(8), .FDIV_W(8)) i_audio_clk_master (
    .clk(clk), .rst_n(rst_n), .en(en), .bdiv_i(bdiv), .fdiv_i(fdiv), .tdm_i(tdm),
    .bclk_o(bclk), .fclk_o(fclk), .bclk_rise_o(rise), .bclk_fall_o(fall),
    .frame_start_o(fstart)
  );

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  initial begin : model
    forever begin
      @(posedge clk);
      cycles++;
      first = 0;
      if (!rst_n || !en) begin
        run = 0; sc = 0; bi = 0;
      end else if (!run) begin
        run = 1; first = 1;
      end else begin
        int last;
        last = tdm ? 255 : int'(fdiv);
        sc++;
        if (sc > int'(bdiv)) begin
          sc = 0;
          bi++;
          if (bi > last) bi = 0;
        end
      end
      #1;
      begin
        int d, hi, len;
        bit eb, ef;
        string tb_tag, tf_tag;
        d   = int'(bdiv) + 1;
        hi  = d / 2;
        len = tdm ? 256 : int'(fdiv) + 1;
        if (!run) begin
          check("R9", "bclk", bclk, 1'b0);
          check("R9", "fclk", fclk, 1'b0);
          check("R9", "rise", rise, 1'b0);
          check("R9", "fall", fall, 1'b0);
          check("R9", "fstart", fstart, 1'b0);
        end else begin
          eb = (d == 1) ? clk : (sc < hi);
          ef = tdm ? (bi == 0) : (bi < len / 2);
          tb_tag = (d == 1) ? "R3" : ((d % 2) ? "R2" : "R1");
          tf_tag = tdm ? "R6" : ((len % 2) ? "R5" : "R4");
          check(tb_tag, "bclk", bclk, eb);
          check(tf_tag, "fclk", fclk, ef);
          check("R7", "rise", rise, sc == 0);
          check("R7", "fall", fall, sc == hi);
          check(first ? "R10" : "R8", "fstart", fstart, (sc == 0) && (bi == 0));
        end
      end
    end
  end

  task automatic reconfig(input logic [7:0] b, input logic [7:0] f, input logic t, input int n);
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
    bdiv = b; fdiv = f; tdm = t;
    @(negedge clk) en = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (600) @(negedge clk);          // D=4, 64-bit frame
    reconfig(8'd4, 8'd6, 1'b0, 200);      // odd D, odd frame
    reconfig(8'd0, 8'd3, 1'b0, 40);       // pass-through
    reconfig(8'd2, 8'd0, 1'b0, 30);       // single-bit frame
    reconfig(8'd1, 8'd5, 1'b1, 1100);     // 256-bit frame, register ignored
    reconfig(8'd1, 8'd200, 1'b1, 600);
    reconfig(8'd5, 8'd31, 1'b0, 100);
    @(negedge clk) rst_n = 1'b0;          // reset mid-run
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (150) @(negedge clk);
    @(negedge clk) en = 1'b0;
    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule